// File: doc/BRIEF.md
# Offset-Addressed Operand Queue Processor

This block is a small execution core whose only operand storage is a circular queue in on-chip registers. There is no register file. An instruction consumes its sources from the head of the queue, so each fetch reads the slot addressed by the head pointer and then advances the pointer by one. It then scatters its result into up to two slots. The address of each slot is the head pointer plus an offset carried in the instruction word. A value can therefore be placed anywhere ahead of the head, and a duplicated operand is just two offsets. No data is moved to make room.

Every slot carries a valid flag. A write sets the flag and a head fetch clears it. This catches the two hazards that offset placement allows: reading a hole, and overwriting a value that has not been consumed yet. A host loads a program into the instruction store and pulses start. The core then steps through fetch, decode, operand read, execute and one or two writeback states for each instruction, until a halt word raises done. After that the host reads back the queue slots through a read port.

Top module: `oqm_core`

## Requirements
- R1: After reset, done_o, busy_o, empty_err_o and coll_err_o are 0 and every queue slot reads back with rd_valid_o = 0.
- R2: Two-source instructions take the first operand A from the slot at the head and the second operand B from the next slot. The head advances by one per fetch, and each fetched slot reads back invalid afterwards.
- R3: Instruction word bits [15:14] hold the operation: 0 = ADD (A+B), 1 = SUB (A−B), 2 = MUL (low 16 bits of A·B), 3 = LDI. All arithmetic is modulo 2^16.
- R4: When bit [13] is 0, ADD, SUB and MUL fetch only A, and B is the immediate in bits [31:16]. When bit [13] is 1, they fetch both operands.
- R5: LDI fetches nothing and its result is the immediate in bits [31:16].
- R6: Each destination address is the head pointer after the instruction's fetches plus a 5-bit offset, modulo 32. Offset 0 is in bits [11:7] and offset 1 is in bits [5:1].
- R7: Bit [12] enables the write through offset 0 and bit [6] enables the write through offset 1. A disabled offset writes no slot.
- R8: A successful write stores the result and marks its slot valid.
- R9: Fetching an invalid slot sets empty_err_o and stops the core for good (busy_o = 0, done_o = 0), and nothing is consumed.
- R10: A write to a slot that is already valid sets coll_err_o and leaves the slot's value untouched. Execution then continues.
- R11: A word with bit [0] set halts the core. done_o rises and holds until the next start.
- R12: A start accepted while not busy clears all slot valid flags, the head pointer, the program counter and both error flags, and runs from instruction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Instruction store write strobe |
| prog_addr_i | input | 4 | Instruction store write address |
| prog_data_i | input | 32 | Instruction word to write |
| start_i | input | 1 | Start execution from instruction 0 |
| rd_addr_i | input | 5 | Queue slot read-back address |
| rd_data_o | output | 16 | Value held in the addressed slot |
| rd_valid_o | output | 1 | Valid flag of the addressed slot |
| busy_o | output | 1 | Core is executing |
| done_o | output | 1 | Halt reached |
| empty_err_o | output | 1 | Fetch of an invalid slot (sticky) |
| coll_err_o | output | 1 | Write to an occupied slot (sticky) |

## Verification
The assertions assume that start_i is pulsed only while busy_o is low, and that the host writes the instruction store only while the core is idle, halted or stalled. The bench keeps within this by loading each program before it pulses start, and by waiting for done_o or empty_err_o before it touches the inputs again. Read-back through rd_addr_i is done only after the core has stopped, so the queue contents are stable while they are sampled.

// File: rtl/oqm_pkg.sv
package oqm_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_LDI = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_DEC,
    S_OPA,
    S_OPB,
    S_EXEC,
    S_WB0,
    S_WB1,
    S_DONE,
    S_STALL
  } state_e;
endpackage

// File: rtl/oqm_imem.sv
module oqm_imem #(
  parameter int IW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/oqm_alu.sv
module oqm_alu
  import oqm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = a_i * b_i;
      default: y_o = imm_i;
    endcase
  end
endmodule

// File: rtl/oqm_queue.sv
// Circular operand store; QDEPTH must be a power of two so addresses wrap.
module oqm_queue #(
  parameter int DATA_W = 16,
  parameter int QDEPTH = 32,
  localparam int QAW   = $clog2(QDEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              pop_i,
  input  logic              wr_en_i,
  input  logic [QAW-1:0]    wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] front_data_o,
  output logic              front_valid_o,
  output logic              wr_hit_o,
  input  logic [QAW-1:0]    rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] mem [QDEPTH];
  logic [QDEPTH-1:0] vld;
  logic [QAW-1:0]    foq;
  logic [QAW-1:0]    wr_addr;
  logic              wr_ok;

  assign wr_addr  = foq + wr_off_i;
  assign wr_hit_o = wr_en_i & vld[wr_addr];
  assign wr_ok    = wr_en_i & ~vld[wr_addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld <= '0;
      foq <= '0;
    end else if (clear_i) begin
      vld <= '0;
      foq <= '0;
    end else begin
      if (pop_i) begin
        vld[foq] <= 1'b0;
        foq      <= foq + 1'b1;
      end
      if (wr_ok) vld[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok && !clear_i) mem[wr_addr] <= wr_data_i;
  end

  assign front_data_o  = mem[foq];
  assign front_valid_o = vld[foq];
  assign rd_data_o     = mem[rd_addr_i];
  assign rd_valid_o    = vld[rd_addr_i];
endmodule

// File: rtl/oqm_seq.sv
module oqm_seq
  import oqm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int QAW    = 5,
  parameter int PCW    = 4,
  localparam int IW    = DATA_W + 2*QAW + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [PCW-1:0]    pc_o,
  input  logic [IW-1:0]     instr_i,
  input  logic [DATA_W-1:0] front_data_i,
  input  logic              front_valid_i,
  input  logic              wr_hit_i,
  output logic              pop_o,
  output logic              clear_o,
  output logic              wr_en_o,
  output logic [QAW-1:0]    wr_off_o,
  output logic [DATA_W-1:0] wr_data_o,
  output op_e               alu_op_o,
  output logic [DATA_W-1:0] alu_a_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic [DATA_W-1:0] alu_imm_o,
  input  logic [DATA_W-1:0] alu_y_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              empty_err_o,
  output logic              coll_err_o
);
  localparam int B_OFF1 = 1;
  localparam int B_EN1  = QAW + 1;
  localparam int B_OFF0 = QAW + 2;
  localparam int B_EN0  = 2*QAW + 2;
  localparam int B_TWO  = 2*QAW + 3;
  localparam int B_OP   = 2*QAW + 4;
  localparam int B_IMM  = 2*QAW + 6;

  state_e            state;
  logic [PCW-1:0]    pc;
  logic [IW-1:0]     ir;
  logic [DATA_W-1:0] opa, opb, res;

  logic              f_halt, f_two, f_en0, f_en1;
  logic [QAW-1:0]    f_off0, f_off1;
  logic [DATA_W-1:0] f_imm;
  op_e               f_op;
  logic              reading;

  assign f_halt = ir[0];
  assign f_off1 = ir[B_OFF1 +: QAW];
  assign f_en1  = ir[B_EN1];
  assign f_off0 = ir[B_OFF0 +: QAW];
  assign f_en0  = ir[B_EN0];
  assign f_two  = ir[B_TWO];
  assign f_op   = op_e'(ir[B_OP +: 2]);
  assign f_imm  = ir[B_IMM +: DATA_W];

  assign busy_o  = !(state inside {S_IDLE, S_DONE, S_STALL});
  assign done_o  = (state == S_DONE);
  assign clear_o = start_i && !busy_o;
  assign reading = (state == S_OPA) || (state == S_OPB);
  assign pop_o   = reading && front_valid_i;

  assign wr_en_o   = ((state == S_WB0) && f_en0) || ((state == S_WB1) && f_en1);
  assign wr_off_o  = (state == S_WB0) ? f_off0 : f_off1;
  assign wr_data_o = res;
  assign pc_o      = pc;

  assign alu_op_o  = f_op;
  assign alu_a_o   = opa;
  assign alu_b_o   = opb;
  assign alu_imm_o = f_imm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      pc          <= '0;
      ir          <= '0;
      opa         <= '0;
      opb         <= '0;
      res         <= '0;
      empty_err_o <= 1'b0;
      coll_err_o  <= 1'b0;
    end else begin
      if (wr_en_o && wr_hit_i) coll_err_o <= 1'b1;
      unique case (state)
        S_IDLE, S_DONE, S_STALL: begin
          if (start_i) begin
            state       <= S_FETCH;
            pc          <= '0;
            empty_err_o <= 1'b0;
            coll_err_o  <= 1'b0;
          end
        end
        S_FETCH: begin
          ir    <= instr_i;
          pc    <= pc + 1'b1;
          state <= S_DEC;
        end
        S_DEC: begin
          if (f_halt)              state <= S_DONE;
          else if (f_op == OP_LDI) state <= S_EXEC;
          else                     state <= S_OPA;
        end
        S_OPA: begin
          if (!front_valid_i) begin
            empty_err_o <= 1'b1;
            state       <= S_STALL;
          end else begin
            opa <= front_data_i;
            if (f_two) state <= S_OPB;
            else begin
              opb   <= f_imm;
              state <= S_EXEC;
            end
          end
        end
        S_OPB: begin
          if (!front_valid_i) begin
            empty_err_o <= 1'b1;
            state       <= S_STALL;
          end else begin
            opb   <= front_data_i;
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          res   <= alu_y_i;
          state <= S_WB0;
        end
        S_WB0:   state <= S_WB1;
        S_WB1:   state <= S_FETCH;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oqm_core.sv
module oqm_core
  import oqm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int QDEPTH     = 32,
  parameter int IMEM_DEPTH = 16,
  localparam int QAW       = $clog2(QDEPTH),
  localparam int PCW       = $clog2(IMEM_DEPTH),
  localparam int IW        = DATA_W + 2*QAW + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PCW-1:0]    prog_addr_i,
  input  logic [IW-1:0]     prog_data_i,
  input  logic              start_i,
  input  logic [QAW-1:0]    rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              empty_err_o,
  output logic              coll_err_o
);
  logic [PCW-1:0]    pc;
  logic [IW-1:0]     instr;
  logic [DATA_W-1:0] front_data, wr_data, alu_a, alu_b, alu_imm, alu_y;
  logic              front_valid, wr_hit, pop, clear, wr_en;
  logic [QAW-1:0]    wr_off;
  op_e               alu_op;

  oqm_imem #(.IW(IW), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc),
    .rdata_o (instr)
  );

  oqm_queue #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_queue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .pop_i         (pop),
    .wr_en_i       (wr_en),
    .wr_off_i      (wr_off),
    .wr_data_i     (wr_data),
    .front_data_o  (front_data),
    .front_valid_o (front_valid),
    .wr_hit_o      (wr_hit),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .rd_valid_o    (rd_valid_o)
  );

  oqm_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (alu_op),
    .a_i   (alu_a),
    .b_i   (alu_b),
    .imm_i (alu_imm),
    .y_o   (alu_y)
  );

  oqm_seq #(.DATA_W(DATA_W), .QAW(QAW), .PCW(PCW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .pc_o          (pc),
    .instr_i       (instr),
    .front_data_i  (front_data),
    .front_valid_i (front_valid),
    .wr_hit_i      (wr_hit),
    .pop_o         (pop),
    .clear_o       (clear),
    .wr_en_o       (wr_en),
    .wr_off_o      (wr_off),
    .wr_data_o     (wr_data),
    .alu_op_o      (alu_op),
    .alu_a_o       (alu_a),
    .alu_b_o       (alu_b),
    .alu_imm_o     (alu_imm),
    .alu_y_i       (alu_y),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .empty_err_o   (empty_err_o),
    .coll_err_o    (coll_err_o)
  );
endmodule

// File: rtl/oqm_chk.sv
module oqm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic done_i,
  input logic empty_err_i,
  input logic coll_err_i,
  input logic pop_i,
  input logic front_valid_i,
  input logic wr_en_i,
  input logic wr_hit_i
);
  // R9
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> front_valid_i);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_err_i && !start_i |=> empty_err_i && !busy_i && !done_i);

  // R10
  coll_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_hit_i |=> coll_err_i);

  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !start_i |=> done_i && !busy_i);

  // R12
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i && !empty_err_i && !coll_err_i && !done_i);
endmodule

bind oqm_core oqm_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_i        (busy_o),
  .done_i        (done_o),
  .empty_err_i   (empty_err_o),
  .coll_err_i    (coll_err_o),
  .pop_i         (pop),
  .front_valid_i (front_valid),
  .wr_en_i       (wr_en),
  .wr_hit_i      (wr_hit)
);

// File: tb/sim_oqm_core.sv
`timescale 1ns/100ps
module sim_oqm_core;
  localparam int DW = 16, QD = 32, QAW = 5, PCW = 4, IW = 32;
  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2, LDI = 2'd3;
  localparam logic [31:0] HALT = 32'h1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic prog_we_i = 1'b0, start_i = 1'b0;
  logic [PCW-1:0] prog_addr_i = '0;
  logic [IW-1:0]  prog_data_i = '0;
  logic [QAW-1:0] rd_addr_i = '0;
  logic [DW-1:0]  rd_data_o;
  logic rd_valid_o, busy_o, done_o, empty_err_o, coll_err_o;

  int checks = 0, errors = 0;

  oqm_core #(.DATA_W(DW), .QDEPTH(QD), .IMEM_DEPTH(16)) u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] op, bit two, bit e0, logic [4:0] o0,
                                     bit e1, logic [4:0] o1, logic [15:0] imm);
    return {imm, op, two, e0, o0, e1, o1, 1'b0};
  endfunction

  task automatic load(int idx, logic [31:0] w);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = PCW'(idx); prog_data_i = w;
    @(posedge clk_i); #1;
    prog_we_i = 1'b0;
  endtask

  task automatic run(string tag);
    int n = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && !empty_err_o && n < 600) begin
      @(negedge clk_i); n++;
    end
    if (n >= 600) begin
      checks++; errors++;
      $display("FAIL %s run timeout actual=busy expected=stop", tag);
    end
  endtask

  task automatic rd(int a, output logic [15:0] d, output logic v);
    rd_addr_i = QAW'(a); #1;
    d = rd_data_o; v = rd_valid_o;
  endtask

  task automatic nvalid(output int n);
    logic [15:0] d; logic v;
    n = 0;
    for (int i = 0; i < QD; i++) begin rd(i, d, v); if (v) n++; end
  endtask

  function automatic logic [15:0] calc(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      ADD: return a + b;
      SUB: return a - b;
      default: return a * b;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] vals [7] = '{16'd0, 16'd1, 16'd2, 16'd7, 16'd255, 16'h8001, 16'hFFFF};
    logic [15:0] d; logic v; int n;
    logic [4:0] bsel [4] = '{5'd0, 5'd5, 5'd17, 5'd31};

    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 done", done_o, 0); chk("R1 busy", busy_o, 0);
    chk("R1 empty_err", empty_err_o, 0); chk("R1 coll_err", coll_err_o, 0);
    nvalid(n); chk("R1 valid count", n, 0);
    rst_ni = 1'b1;

    // R2 R3 R6 R8 R11: (x+y)*(x-z) through offset placement
    load(0, mk(LDI, 0, 1, 5'd1, 0, 5'd0, 16'd0)); // placeholder, overwritten per run
    for (int ix = 0; ix < 7; ix++)
      for (int iy = 0; iy < 7; iy++)
        for (int iz = 0; iz < 7; iz++) begin
          load(0, mk(LDI, 0, 1, 5'd0, 1, 5'd2, vals[ix]));
          load(1, mk(LDI, 0, 1, 5'd1, 0, 5'd0, vals[iy]));
          load(2, mk(LDI, 0, 1, 5'd3, 0, 5'd0, vals[iz]));
          load(3, mk(ADD, 1, 1, 5'd2, 0, 5'd0, 16'd0));
          load(4, mk(SUB, 1, 1, 5'd1, 0, 5'd0, 16'd0));
          load(5, mk(MUL, 1, 1, 5'd0, 0, 5'd0, 16'd0));
          load(6, HALT);
          run("R11 expr");
          chk("R11 done", done_o, 1);
          rd(6, d, v);
          chk("R3 R6 expr result", d, 16'((vals[ix] + vals[iy]) * (vals[ix] - vals[iz])));
          nvalid(n);
          chk("R2 R8 only result slot valid", {n[15:0], 15'd0, v}, {16'd1, 15'd0, 1'b1});
        end

    // R3 two-source ops, R4 single-source ops with immediate
    for (int op = 0; op < 3; op++)
      for (int ia = 0; ia < 7; ia++)
        for (int ib = 0; ib < 7; ib++) begin
          load(0, mk(LDI, 0, 1, 5'd0, 0, 5'd0, vals[ia]));
          load(1, mk(LDI, 0, 1, 5'd1, 0, 5'd0, vals[ib]));
          load(2, mk(2'(op), 1, 1, 5'd0, 0, 5'd0, 16'd0));
          load(3, HALT);
          run("R3 op2");
          rd(2, d, v);
          chk("R3 two-source result", {d, 15'd0, v}, {calc(2'(op), vals[ia], vals[ib]), 15'd0, 1'b1});
          load(1, mk(2'(op), 0, 1, 5'd0, 0, 5'd0, vals[ib]));
          load(2, HALT);
          run("R4 op1");
          rd(1, d, v);
          chk("R4 single-source result", {d, 15'd0, v}, {calc(2'(op), vals[ia], vals[ib]), 15'd0, 1'b1});
          rd(0, d, v);
          chk("R2 fetched slot invalid", v, 0);
        end

    // R5 LDI consumes nothing
    load(0, mk(LDI, 1, 1, 5'd0, 0, 5'd0, 16'hA5A5));
    load(1, mk(LDI, 1, 1, 5'd1, 0, 5'd0, 16'h5A5A));
    load(2, HALT);
    run("R5");
    nvalid(n); chk("R5 no fetch by LDI", n, 2);
    rd(0, d, v); chk("R5 slot0", d, 16'hA5A5);
    rd(1, d, v); chk("R5 slot1", d, 16'h5A5A);

    // R6 R7 scatter over offsets
    for (int a = 0; a < 32; a++)
      for (int k = 0; k < 4; k++) begin
        if (bsel[k] == 5'(a)) continue;
        load(0, mk(LDI, 0, 1, 5'(a), 1, bsel[k], 16'(a * 97 + k)));
        load(1, HALT);
        run("R6 scatter");
        rd(a, d, v); chk("R6 offset0 slot", {d, 15'd0, v}, {16'(a * 97 + k), 15'd0, 1'b1});
        rd(bsel[k], d, v); chk("R6 offset1 slot", {d, 15'd0, v}, {16'(a * 97 + k), 15'd0, 1'b1});
        nvalid(n); chk("R7 exactly two slots", n, 2);
      end

    // R7 enables
    load(0, mk(LDI, 0, 0, 5'd3, 1, 5'd9, 16'h1111)); load(1, HALT); run("R7");
    nvalid(n); chk("R7 en1 only count", n, 1);
    rd(9, d, v); chk("R7 en1 only slot", {d, 15'd0, v}, {16'h1111, 15'd0, 1'b1});
    load(0, mk(LDI, 0, 1, 5'd3, 0, 5'd9, 16'h2222)); run("R7");
    nvalid(n); chk("R7 en0 only count", n, 1);
    rd(3, d, v); chk("R7 en0 only slot", {d, 15'd0, v}, {16'h2222, 15'd0, 1'b1});
    load(0, mk(LDI, 0, 0, 5'd3, 0, 5'd9, 16'h3333)); run("R7");
    nvalid(n); chk("R7 no enable count", n, 0);

    // R6 wrap: head at 1, offset 31 -> slot 0
    load(0, mk(LDI, 0, 1, 5'd0, 0, 5'd0, 16'd40));
    load(1, mk(ADD, 0, 1, 5'd31, 0, 5'd0, 16'd2));
    load(2, HALT);
    run("R6 wrap");
    rd(0, d, v); chk("R6 wrap slot0", {d, 15'd0, v}, {16'd42, 15'd0, 1'b1});
    nvalid(n); chk("R6 wrap count", n, 1);

    // R11 done holds
    repeat (10) @(negedge clk_i);
    chk("R11 done held", {done_o, busy_o}, 2'b10);

    // R10 collision by a later instruction
    load(0, mk(LDI, 0, 1, 5'd0, 0, 5'd0, 16'hBEEF));
    load(1, mk(LDI, 0, 1, 5'd0, 0, 5'd0, 16'hDEAD));
    load(2, mk(LDI, 0, 1, 5'd4, 0, 5'd0, 16'h0004));
    load(3, HALT);
    run("R10");
    chk("R10 coll flag", coll_err_o, 1);
    chk("R10 continues to halt", done_o, 1);
    rd(0, d, v); chk("R10 slot unchanged", d, 16'hBEEF);
    rd(4, d, v); chk("R10 later write done", {d, 15'd0, v}, {16'h0004, 15'd0, 1'b1});

    // R12 restart clears
    load(0, HALT);
    run("R12");
    chk("R12 coll cleared", coll_err_o, 0);
    nvalid(n); chk("R12 slots cleared", n, 0);

    // R10 both offsets to the same slot
    load(0, mk(LDI, 0, 1, 5'd3, 1, 5'd3, 16'h7777)); load(1, HALT);
    run("R10 dual");
    chk("R10 dual coll", coll_err_o, 1);
    nvalid(n); chk("R10 dual count", n, 1);
    rd(3, d, v); chk("R10 dual value", d, 16'h7777);

    // R9 empty fetch stalls, nothing consumed
    load(0, mk(LDI, 0, 1, 5'd1, 0, 5'd0, 16'h1234));
    load(1, mk(ADD, 1, 1, 5'd5, 0, 5'd0, 16'd0));
    load(2, HALT);
    run("R9");
    repeat (20) @(negedge clk_i);
    chk("R9 empty flag", empty_err_o, 1);
    chk("R9 stalled not done/busy", {done_o, busy_o}, 2'b00);
    rd(1, d, v); chk("R9 slot1 kept", {d, 15'd0, v}, {16'h1234, 15'd0, 1'b1});
    nvalid(n); chk("R9 count", n, 1);

    // R12 restart from stall
    load(0, HALT);
    run("R12 stall");
    chk("R12 empty cleared", {empty_err_o, done_o}, 2'b01);
    nvalid(n); chk("R12 stall slots cleared", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule